// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block sits beside a small microcontroller core and decides when the core sleeps. It offers two low-power states. In idle, the CPU clock is gated while the peripheral clock keeps running. In power-down, both clocks stop. Each state is entered only through a guarded pair of control writes on two back-to-back instructions. This makes an accidental stray write unlikely to put the chip to sleep.

Idle ends on any enabled interrupt request or on reset. Power-down ends only on reset. When a sleep state ends, both mode bits clear and the CPU clock returns, so execution continues with the instruction after the second write. While asleep, the block drives the chip pins itself:
- the address-latch strobe and the program-store strobe;
- the multiplexed low address/data port;
- the high address port;
- a set of general-purpose ports.

Their values depend on the sleep state and on whether the last code fetch came from external memory.

A control write counts only in a cycle where the core also signals an instruction boundary. The write then retires together with that instruction.

Top module: `pwr_idle_ctl`

## Requirements
- R1: Idle is entered on the clock edge at a boundary whose write has control bit 1 set, when the previous boundary's write had bit 0 set. Afterwards `mode_o` = 01 and `req_o` = 0010.
- R2: At a boundary, bit 0 of an accepted write sets the idle-armed flag (`req_o[0]`), and every other boundary clears it. A bit-1 write without the armed flag does nothing. A write without `instr_done_i` is ignored.
- R3: Power-down uses bit 2 to arm (`req_o[2]`) and bit 3 to commit, with the same back-to-back rule. Afterwards `mode_o` = 10 and `req_o` = 1000.
- R4: `cpu_clk_en_o` is 1 only in run mode (00). `per_clk_en_o` is 1 in run and idle and 0 in power-down.
- R5: `irq_pend_i` in idle returns the block to run on the next edge with `req_o` = 0000. In power-down and in run it has no effect.
- R6: Active-low `rst_ni` takes effect asynchronously and has priority over all inputs. It gives mode 00, `req_o` 0000 and both clock enables at 1.
- R7: In run, `ale_o` and `psen_o` follow `ale_i` and `psen_i`. In idle both are 1; in power-down both are 0.
- R8: Asleep, general ports show the output they had at entry. In idle, bits whose alternate function was enabled at entry follow `gp_alt_i` live. In power-down, all bits are frozen.
- R9: Asleep, the low port floats (`ad_lo_oe_o` = 0) if `ext_fetch_i` was 1 at entry. Otherwise it drives `ad_lo_i` as captured at entry.
- R10: After an external-fetch entry, `hi_o` shows the `hi_addr_i` captured at entry while in idle, and the captured `hi_sfr_i` while in power-down. After an internal entry it shows the captured `hi_sfr_i` in both states.
- R11: One write with both bits 0 and 1 set only arms idle. If both modes are armed and one write commits both, power-down wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_done_i | input | 1 | Instruction boundary pulse |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Write data: bit0 idle arm, bit1 idle commit, bit2 down arm, bit3 down commit |
| irq_pend_i | input | 1 | Enabled interrupt request |
| ext_fetch_i | input | 1 | Current fetch is from external code memory |
| ale_i | input | 1 | Address-latch strobe from core |
| psen_i | input | 1 | Program-store strobe from core |
| ad_lo_i | input | PORT_W | Low port output value from core |
| ad_lo_oe_i | input | 1 | Low port drive enable from core |
| hi_sfr_i | input | PORT_W | High port latch data |
| hi_addr_i | input | PORT_W | Current high address byte |
| gp_dat_i | input | GP_PORTS*PORT_W | General port latch data |
| gp_alt_en_i | input | GP_PORTS*PORT_W | Alternate function enable per bit |
| gp_alt_i | input | GP_PORTS*PORT_W | Alternate function output per bit |
| mode_o | output | 2 | 00 run, 01 idle, 10 power-down |
| req_o | output | 4 | Mode request bits, same positions as write data |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| ale_o | output | 1 | Address-latch strobe pin |
| psen_o | output | 1 | Program-store strobe pin |
| ad_lo_o | output | PORT_W | Low port pin value |
| ad_lo_oe_o | output | 1 | Low port drive enable |
| hi_o | output | PORT_W | High port pin value |
| gp_o | output | GP_PORTS*PORT_W | General port pin values |

## Verification
A wrong guard state shows one edge after the commit write, as a wrong `mode_o` and wrong clock enables. A wrong armed flag is visible on `req_o` right after the arming boundary. A bad entry snapshot only shows once the block sleeps: the bench changes every pin input after entry, so a live path where a frozen one belongs shows at once on `gp_o`, `hi_o` or `ad_lo_o`. A wrong exit path shows on the edge after the interrupt, as a mode or request bits that do not clear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_IDLE = 2'b01,
      PM_DOWN = 2'b10
   } pm_mode_e;

   // control bit positions (decoded by the core's write data)
   localparam int CB_IDLE_ARM = 0;
   localparam int CB_IDLE_GO  = 1;
   localparam int CB_DOWN_ARM = 2;
   localparam int CB_DOWN_GO  = 3;
   localparam int CB_W        = 4;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            instr_done_i,
   input  logic            ctl_wr_i,
   input  logic [CB_W-1:0] ctl_wdata_i,
   input  logic            irq_pend_i,
   output pm_mode_e        mode_q,
   output logic [CB_W-1:0] req_q,
   output logic            enter_stb
);
   pm_mode_e        mode_n;
   logic [CB_W-1:0] req_n;
   logic            take, idle_fire, down_fire;

   assign take      = ctl_wr_i & instr_done_i & (mode_q == PM_RUN);
   assign idle_fire = take & ctl_wdata_i[CB_IDLE_GO] & req_q[CB_IDLE_ARM];
   assign down_fire = take & ctl_wdata_i[CB_DOWN_GO] & req_q[CB_DOWN_ARM];
   assign enter_stb = idle_fire | down_fire;

   always_comb begin
      mode_n = mode_q;
      req_n  = req_q;
      unique case (mode_q)
         PM_RUN: begin
            if (down_fire) begin
               mode_n = PM_DOWN;
               req_n = '0;
               req_n[CB_DOWN_GO] = 1'b1;
            end else if (idle_fire) begin
               mode_n = PM_IDLE;
               req_n = '0;
               req_n[CB_IDLE_GO] = 1'b1;
            end else if (instr_done_i) begin
               req_n = '0;
               if (take) begin
                  req_n[CB_IDLE_ARM] = ctl_wdata_i[CB_IDLE_ARM];
                  req_n[CB_DOWN_ARM] = ctl_wdata_i[CB_DOWN_ARM];
               end
            end
         end
         PM_IDLE: begin
            if (irq_pend_i) begin
               mode_n = PM_RUN;
               req_n  = '0;
            end
         end
         PM_DOWN: begin
            mode_n = PM_DOWN;
         end
         default: begin
            mode_n = PM_RUN;
            req_n  = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= PM_RUN;
         req_q  <= '0;
      end else begin
         mode_q <= mode_n;
         req_q  <= req_n;
      end
   end
endmodule

// File: rtl/pmc_snap.sv
module pmc_snap #(
   parameter int PORT_W   = 8,
   parameter int GP_PORTS = 5,
   localparam int GP_W    = PORT_W * GP_PORTS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enter_stb,
   input  logic              ext_fetch_i,
   input  logic [PORT_W-1:0] ad_lo_i,
   input  logic [PORT_W-1:0] hi_sfr_i,
   input  logic [PORT_W-1:0] hi_addr_i,
   input  logic [GP_W-1:0]   gp_dat_i,
   input  logic [GP_W-1:0]   gp_alt_en_i,
   input  logic [GP_W-1:0]   gp_alt_i,
   output logic              ext_q,
   output logic [PORT_W-1:0] ad_lo_q,
   output logic [PORT_W-1:0] hi_sfr_q,
   output logic [PORT_W-1:0] hi_addr_q,
   output logic [GP_W-1:0]   gp_out_q,
   output logic [GP_W-1:0]   gp_alt_en_q
);
   logic [GP_W-1:0] gp_run;

   assign gp_run = (gp_alt_en_i & gp_alt_i) | (~gp_alt_en_i & gp_dat_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ext_q       <= 1'b0;
         ad_lo_q     <= '0;
         hi_sfr_q    <= '0;
         hi_addr_q   <= '0;
         gp_out_q    <= '0;
         gp_alt_en_q <= '0;
      end else if (enter_stb) begin
         ext_q       <= ext_fetch_i;
         ad_lo_q     <= ad_lo_i;
         hi_sfr_q    <= hi_sfr_i;
         hi_addr_q   <= hi_addr_i;
         gp_out_q    <= gp_run;
         gp_alt_en_q <= gp_alt_en_i;
      end
   end
endmodule

// File: rtl/pmc_pins.sv
module pmc_pins
   import pmc_pkg::*;
#(
   parameter int PORT_W   = 8,
   parameter int GP_PORTS = 5,
   localparam int GP_W    = PORT_W * GP_PORTS
) (
   input  pm_mode_e          mode_i,
   input  logic              ext_fetch_i,
   input  logic              ale_i,
   input  logic              psen_i,
   input  logic [PORT_W-1:0] ad_lo_i,
   input  logic              ad_lo_oe_i,
   input  logic [PORT_W-1:0] hi_sfr_i,
   input  logic [PORT_W-1:0] hi_addr_i,
   input  logic [GP_W-1:0]   gp_dat_i,
   input  logic [GP_W-1:0]   gp_alt_en_i,
   input  logic [GP_W-1:0]   gp_alt_i,
   input  logic              ext_q,
   input  logic [PORT_W-1:0] ad_lo_q,
   input  logic [PORT_W-1:0] hi_sfr_q,
   input  logic [PORT_W-1:0] hi_addr_q,
   input  logic [GP_W-1:0]   gp_out_q,
   input  logic [GP_W-1:0]   gp_alt_en_q,
   output logic              cpu_clk_en_o,
   output logic              per_clk_en_o,
   output logic              ale_o,
   output logic              psen_o,
   output logic [PORT_W-1:0] ad_lo_o,
   output logic              ad_lo_oe_o,
   output logic [PORT_W-1:0] hi_o,
   output logic [GP_W-1:0]   gp_o
);
   logic is_run, is_idle;

   assign is_run       = (mode_i == PM_RUN);
   assign is_idle      = (mode_i == PM_IDLE);
   assign cpu_clk_en_o = is_run;
   assign per_clk_en_o = (mode_i != PM_DOWN);

   always_comb begin
      if (is_run) begin
         ale_o      = ale_i;
         psen_o     = psen_i;
         ad_lo_o    = ad_lo_i;
         ad_lo_oe_o = ad_lo_oe_i;
         hi_o       = ext_fetch_i ? hi_addr_i : hi_sfr_i;
      end else begin
         ale_o      = is_idle;
         psen_o     = is_idle;
         ad_lo_o    = ad_lo_q;
         ad_lo_oe_o = ~ext_q;
         hi_o       = (ext_q && is_idle) ? hi_addr_q : hi_sfr_q;
      end
   end

   for (genvar p = 0; p < GP_PORTS; p++) begin : g_port
      localparam int LO = p * PORT_W;
      logic [PORT_W-1:0] run_v, idle_v;
      assign run_v  = (gp_alt_en_i[LO +: PORT_W] & gp_alt_i[LO +: PORT_W])
                    | (~gp_alt_en_i[LO +: PORT_W] & gp_dat_i[LO +: PORT_W]);
      assign idle_v = (gp_alt_en_q[LO +: PORT_W] & gp_alt_i[LO +: PORT_W])
                    | (~gp_alt_en_q[LO +: PORT_W] & gp_out_q[LO +: PORT_W]);
      assign gp_o[LO +: PORT_W] = is_run  ? run_v  :
                                  is_idle ? idle_v : gp_out_q[LO +: PORT_W];
   end
endmodule

// File: rtl/pwr_idle_ctl.sv
module pwr_idle_ctl
   import pmc_pkg::*;
#(
   parameter int PORT_W   = 8,
   parameter int GP_PORTS = 5,
   localparam int GP_W    = PORT_W * GP_PORTS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              instr_done_i,
   input  logic              ctl_wr_i,
   input  logic [3:0]        ctl_wdata_i,
   input  logic              irq_pend_i,
   input  logic              ext_fetch_i,
   input  logic              ale_i,
   input  logic              psen_i,
   input  logic [PORT_W-1:0] ad_lo_i,
   input  logic              ad_lo_oe_i,
   input  logic [PORT_W-1:0] hi_sfr_i,
   input  logic [PORT_W-1:0] hi_addr_i,
   input  logic [GP_W-1:0]   gp_dat_i,
   input  logic [GP_W-1:0]   gp_alt_en_i,
   input  logic [GP_W-1:0]   gp_alt_i,
   output logic [1:0]        mode_o,
   output logic [3:0]        req_o,
   output logic              cpu_clk_en_o,
   output logic              per_clk_en_o,
   output logic              ale_o,
   output logic              psen_o,
   output logic [PORT_W-1:0] ad_lo_o,
   output logic              ad_lo_oe_o,
   output logic [PORT_W-1:0] hi_o,
   output logic [GP_W-1:0]   gp_o
);
   if (PORT_W < 1) begin : g_bad_port_w
      $error("pwr_idle_ctl: PORT_W must be at least 1");
   end
   if (GP_PORTS < 1) begin : g_bad_gp_ports
      $error("pwr_idle_ctl: GP_PORTS must be at least 1");
   end

   pm_mode_e          mode_q;
   logic [CB_W-1:0]   req_q;
   logic              enter_stb, ext_q;
   logic [PORT_W-1:0] ad_lo_q, hi_sfr_q, hi_addr_q;
   logic [GP_W-1:0]   gp_out_q, gp_alt_en_q;

   pmc_seq u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .instr_done_i (instr_done_i),
      .ctl_wr_i     (ctl_wr_i),
      .ctl_wdata_i  (ctl_wdata_i),
      .irq_pend_i   (irq_pend_i),
      .mode_q       (mode_q),
      .req_q        (req_q),
      .enter_stb    (enter_stb)
   );

   pmc_snap #(.PORT_W(PORT_W), .GP_PORTS(GP_PORTS)) u_snap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enter_stb   (enter_stb),
      .ext_fetch_i (ext_fetch_i),
      .ad_lo_i     (ad_lo_i),
      .hi_sfr_i    (hi_sfr_i),
      .hi_addr_i   (hi_addr_i),
      .gp_dat_i    (gp_dat_i),
      .gp_alt_en_i (gp_alt_en_i),
      .gp_alt_i    (gp_alt_i),
      .ext_q       (ext_q),
      .ad_lo_q     (ad_lo_q),
      .hi_sfr_q    (hi_sfr_q),
      .hi_addr_q   (hi_addr_q),
      .gp_out_q    (gp_out_q),
      .gp_alt_en_q (gp_alt_en_q)
   );

   pmc_pins #(.PORT_W(PORT_W), .GP_PORTS(GP_PORTS)) u_pins (
      .mode_i       (mode_q),
      .ext_fetch_i  (ext_fetch_i),
      .ale_i        (ale_i),
      .psen_i       (psen_i),
      .ad_lo_i      (ad_lo_i),
      .ad_lo_oe_i   (ad_lo_oe_i),
      .hi_sfr_i     (hi_sfr_i),
      .hi_addr_i    (hi_addr_i),
      .gp_dat_i     (gp_dat_i),
      .gp_alt_en_i  (gp_alt_en_i),
      .gp_alt_i     (gp_alt_i),
      .ext_q        (ext_q),
      .ad_lo_q      (ad_lo_q),
      .hi_sfr_q     (hi_sfr_q),
      .hi_addr_q    (hi_addr_q),
      .gp_out_q     (gp_out_q),
      .gp_alt_en_q  (gp_alt_en_q),
      .cpu_clk_en_o (cpu_clk_en_o),
      .per_clk_en_o (per_clk_en_o),
      .ale_o        (ale_o),
      .psen_o       (psen_o),
      .ad_lo_o      (ad_lo_o),
      .ad_lo_oe_o   (ad_lo_oe_o),
      .hi_o         (hi_o),
      .gp_o         (gp_o)
   );

   assign mode_o = mode_q;
   assign req_o  = req_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       instr_done_i,
   input logic       ctl_wr_i,
   input logic [3:0] ctl_wdata_i,
   input logic       irq_pend_i,
   input logic [1:0] mode_o,
   input logic [3:0] req_o,
   input logic       cpu_clk_en_o,
   input logic       per_clk_en_o,
   input logic       ale_o,
   input logic       psen_o
);
   AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b00 && instr_done_i && ctl_wr_i && ctl_wdata_i[1] && req_o[0]
       && !(ctl_wdata_i[3] && req_o[2])) |=> (mode_o == 2'b01)); // R1
   AST_NO_UNARMED_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b00 && !req_o[0] && !req_o[2]) |=> (mode_o == 2'b00)); // R2
   AST_DOWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10) |=> (mode_o == 2'b10 && req_o == 4'b1000)); // R3
   AST_CLK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_clk_en_o |-> per_clk_en_o); // R4
   AST_IRQ_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b01 && irq_pend_i) |=> (mode_o == 2'b00 && req_o == 4'b0000)); // R5
   AST_IDLE_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b01) |-> (ale_o && psen_o)); // R7
   AST_DOWN_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10) |-> (!ale_o && !psen_o)); // R7
   AST_ONE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({req_o[3], req_o[1]})); // R11
endmodule

bind pwr_idle_ctl pmc_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .instr_done_i (instr_done_i),
   .ctl_wr_i     (ctl_wr_i),
   .ctl_wdata_i  (ctl_wdata_i),
   .irq_pend_i   (irq_pend_i),
   .mode_o       (mode_o),
   .req_o        (req_o),
   .cpu_clk_en_o (cpu_clk_en_o),
   .per_clk_en_o (per_clk_en_o),
   .ale_o        (ale_o),
   .psen_o       (psen_o)
);

// File: tb/pwr_idle_ctl_tb.sv
`timescale 1ns/1ps
module pwr_idle_ctl_tb;
   localparam int PW = 8;
   localparam int GW = 40;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          instr_done_i = 1'b0, ctl_wr_i = 1'b0, irq_pend_i = 1'b0;
   logic [3:0]    ctl_wdata_i = '0;
   logic          ext_fetch_i = 1'b0, ale_i = 1'b0, psen_i = 1'b0, ad_lo_oe_i = 1'b0;
   logic [PW-1:0] ad_lo_i = '0, hi_sfr_i = '0, hi_addr_i = '0;
   logic [GW-1:0] gp_dat_i = '0, gp_alt_en_i = '0, gp_alt_i = '0;
   logic [1:0]    mode_o;
   logic [3:0]    req_o;
   logic          cpu_clk_en_o, per_clk_en_o, ale_o, psen_o, ad_lo_oe_o;
   logic [PW-1:0] ad_lo_o, hi_o;
   logic [GW-1:0] gp_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk_i = ~clk_i;

   pwr_idle_ctl u_dut (.*);

   // vector: [12] boundary [11] write [10:7] data [6] irq [5:4] mode [3:0] req
   localparam int NV = 11;
   localparam logic [12:0] VEC [NV] = '{
      {1'b0, 1'b0, 4'b0000, 1'b0, 2'b00, 4'b0000},  // idle step, R6
      {1'b1, 1'b1, 4'b0001, 1'b0, 2'b00, 4'b0001},  // arm idle, R2
      {1'b1, 1'b0, 4'b0000, 1'b0, 2'b00, 4'b0000},  // boundary clears arm, R2
      {1'b1, 1'b1, 4'b0010, 1'b0, 2'b00, 4'b0000},  // commit unarmed, R2
      {1'b1, 1'b1, 4'b0001, 1'b0, 2'b00, 4'b0001},  // arm again
      {1'b0, 1'b1, 4'b0010, 1'b0, 2'b00, 4'b0001},  // write w/o boundary ignored, R2
      {1'b1, 1'b1, 4'b0010, 1'b0, 2'b01, 4'b0010},  // enter idle, R1
      {1'b0, 1'b0, 4'b0000, 1'b1, 2'b00, 4'b0000},  // irq wakes, R5
      {1'b1, 1'b1, 4'b0100, 1'b0, 2'b00, 4'b0100},  // arm down, R3
      {1'b1, 1'b1, 4'b1000, 1'b0, 2'b10, 4'b1000},  // enter down, R3
      {1'b0, 1'b0, 4'b0000, 1'b1, 2'b10, 4'b1000}   // irq ignored in down, R5
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic wr_bnd(input logic [3:0] d);
      ctl_wr_i = 1'b1; ctl_wdata_i = d; instr_done_i = 1'b1;
      step();
      ctl_wr_i = 1'b0; ctl_wdata_i = '0; instr_done_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      #1;
      chk("R6 mode in reset", 64'(mode_o), 64'h0);
      chk("R6 req in reset", 64'(req_o), 64'h0);
      step();
      rst_ni = 1'b1;
   endtask

   task automatic setup_entry(input logic ext);
      ext_fetch_i = ext;
      gp_dat_i = 40'h1122334455; gp_alt_en_i = 40'h00000000FF; gp_alt_i = 40'h00000000AA;
      ad_lo_i = 8'hA5; hi_sfr_i = 8'h3C; hi_addr_i = 8'hC3; ad_lo_oe_i = 1'b1;
   endtask

   task automatic scramble();
      ext_fetch_i = ~ext_fetch_i;
      gp_dat_i = '0; gp_alt_en_i = '1; gp_alt_i = 40'h00000000F0;
      ad_lo_i = 8'h00; hi_sfr_i = 8'h00; hi_addr_i = 8'h00;
      ale_i = 1'b0; psen_i = 1'b0;
      #1;
   endtask

   initial begin
      #(20000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk_i);
      do_reset();
      chk("R4 run cpu clk", 64'(cpu_clk_en_o), 64'h1);
      chk("R4 run per clk", 64'(per_clk_en_o), 64'h1);

      for (int i = 0; i < NV; i++) begin
         instr_done_i = VEC[i][12]; ctl_wr_i = VEC[i][11];
         ctl_wdata_i = VEC[i][10:7]; irq_pend_i = VEC[i][6];
         step();
         instr_done_i = 1'b0; ctl_wr_i = 1'b0; ctl_wdata_i = '0; irq_pend_i = 1'b0;
         chk($sformatf("R1/R2/R3/R5 vec %0d mode", i), 64'(mode_o), 64'(VEC[i][5:4]));
         chk($sformatf("R1/R2/R3/R5 vec %0d req", i), 64'(req_o), 64'(VEC[i][3:0]));
      end
      chk("R4 down cpu clk", 64'(cpu_clk_en_o), 64'h0);
      chk("R4 down per clk", 64'(per_clk_en_o), 64'h0);

      // R6: reset beats irq and write
      irq_pend_i = 1'b1; ctl_wr_i = 1'b1; ctl_wdata_i = 4'b0001; instr_done_i = 1'b1;
      rst_ni = 1'b0; #1;
      chk("R6 async reset mode", 64'(mode_o), 64'h0);
      step(); step();
      chk("R6 held reset req", 64'(req_o), 64'h0);
      irq_pend_i = 1'b0; ctl_wr_i = 1'b0; ctl_wdata_i = '0; instr_done_i = 1'b0;
      rst_ni = 1'b1;

      // R7 run pass-through
      ale_i = 1'b1; psen_i = 1'b0; #1;
      chk("R7 run ale", 64'(ale_o), 64'h1);
      chk("R7 run psen", 64'(psen_o), 64'h0);

      // R11 both bits in one write only arm
      wr_bnd(4'b0011);
      chk("R11 same-write arm", 64'(req_o), 64'b0001);
      wr_bnd(4'b0000);

      // idle, internal fetch
      setup_entry(1'b0);
      wr_bnd(4'b0001); wr_bnd(4'b0010);
      chk("R1 idle entered", 64'(mode_o), 64'h1);
      scramble();
      chk("R4 idle cpu clk", 64'(cpu_clk_en_o), 64'h0);
      chk("R4 idle per clk", 64'(per_clk_en_o), 64'h1);
      chk("R7 idle ale", 64'(ale_o), 64'h1);
      chk("R7 idle psen", 64'(psen_o), 64'h1);
      chk("R8 idle gp hold+alt", 64'(gp_o), 64'h11223344F0);
      chk("R9 int idle oe", 64'(ad_lo_oe_o), 64'h1);
      chk("R9 int idle data", 64'(ad_lo_o), 64'hA5);
      chk("R10 int idle hi", 64'(hi_o), 64'h3C);
      irq_pend_i = 1'b1; step(); irq_pend_i = 1'b0;
      chk("R5 wake mode", 64'(mode_o), 64'h0);
      chk("R4 wake cpu clk", 64'(cpu_clk_en_o), 64'h1);

      // idle, external fetch
      setup_entry(1'b1);
      wr_bnd(4'b0001); wr_bnd(4'b0010);
      scramble();
      chk("R9 ext idle float", 64'(ad_lo_oe_o), 64'h0);
      chk("R10 ext idle addr", 64'(hi_o), 64'hC3);
      irq_pend_i = 1'b1; step(); irq_pend_i = 1'b0;

      // power-down, external fetch, R11 priority
      setup_entry(1'b1);
      wr_bnd(4'b0101); wr_bnd(4'b1010);
      chk("R11 down wins", 64'(mode_o), 64'h2);
      scramble();
      chk("R7 down ale", 64'(ale_o), 64'h0);
      chk("R7 down psen", 64'(psen_o), 64'h0);
      chk("R8 down gp frozen", 64'(gp_o), 64'h11223344AA);
      chk("R9 ext down float", 64'(ad_lo_oe_o), 64'h0);
      chk("R10 ext down data", 64'(hi_o), 64'h3C);
      do_reset();

      // power-down, internal fetch
      setup_entry(1'b0);
      wr_bnd(4'b0100); wr_bnd(4'b1000);
      scramble();
      chk("R9 int down oe", 64'(ad_lo_oe_o), 64'h1);
      chk("R9 int down data", 64'(ad_lo_o), 64'hA5);
      chk("R10 int down hi", 64'(hi_o), 64'h3C);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule